// File: doc/BRIEF.md
# Column Command Packet Decoder

This block takes the column control lane of a packet-based memory device, five pins sampled once per clock, and turns each framed 40-bit packet into command strobes. A high level on the top pin while the block is idle marks the first slot of a packet. The following seven slots complete it. The first 23 bits form the column-operation part: device, bank, column and a four-bit opcode. The last 17 bits form a secondary part, selected by a mode bit. That secondary part is either a pair of bytemasks or an extended operation with its own device, bank and opcode.

A controller uses the column part to issue reads, writes, precharges and relax-to-standby requests to one device on a shared lane. The extended part lets it precharge another bank of that device without spending a row-lane packet. A bytemask part does not name a device. It applies to the write that this device accepted in the packet just before it. A bytemask part with no such write behind it is dropped, and the block reports it on a flag.

Top module: `colpkt_decoder`

## Requirements
- R1: While idle, a cycle with `col_in[4]` high starts a packet. That cycle and the next seven are its slots. The pins of slot k fill packet bits [39-5k : 35-5k], with bit 4 of the pins going to the highest bit. `col_in[4]` high inside a packet is data and does not start a packet. A new packet may start in the cycle right after a last slot.
- R2: The packet fields are: start bit at 39, device at [38:34], bank at [33:29], column at [28:23], opcode at [22:19], and ignored bits [18:17]. A column command is accepted only when the device equals `dev_id` and `attn` is high in the cycle after the last slot. An accepted read, write or precharge loads `col_bank` and `col_addr`, and those outputs hold their value otherwise.
- R3: Opcode bits [2:0] decode as follows. 001 is a write. 011 is a read. 100 is a precharge. 101 is a write plus precharge. 111 is a read plus precharge. 000, 010 and 110 issue nothing.
- R4: Opcode bit 3 requests relax-to-standby on `relax_stb` and combines with any value of the lower three bits.
- R5: When the mode bit (bit 16) is 0, the extended part holds a device at [15:11], a bank at [10:6] and an opcode at [5:1]. It is decoded only when that device equals `dev_id` and `attn` is high. Extended opcode bit 4 gives `xpre_stb` and loads `x_bank`. Bit 1 gives `relax_stb`. The two may be combined.
- R6: Extended opcode bit 3 gives `cal_stb`. Bits 3 and 2 together also give `sam_stb`. Any extended opcode with bit 0 set is reserved and issues nothing.
- R7: When the mode bit is 1 and the previous packet carried an accepted write, `mask_stb` pulses. `mask_a` is loaded from bits [15:8] and `mask_b` from bits [7:0]. A 1 in a mask bit means the byte is written, and mask bit 0 is the earliest byte. Any packet ends the pending state of the write before it.
- R8: When the mode bit is 1 and no write is pending, `mask_orphan` pulses and `mask_a` and `mask_b` keep their values.
- R9: Every strobe is high for exactly the one cycle after the clock edge that follows the last slot.
- R10: During reset and after it, all strobes and flags are low and all address and mask outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_in | input | 5 | Column lane pins, one slot per cycle |
| dev_id | input | 5 | This device's address |
| attn | input | 1 | High when the device is in the attention power state |
| rd_stb | output | 1 | Read command |
| wr_stb | output | 1 | Write command |
| pre_stb | output | 1 | Precharge of `col_bank` (plain or automatic) |
| relax_stb | output | 1 | Relax-to-standby request, from either part |
| col_bank | output | 5 | Bank of the last column command |
| col_addr | output | 6 | Column of the last column command |
| mask_stb | output | 1 | Bytemask delivered for the pending write |
| mask_orphan | output | 1 | Bytemask arrived with no write pending |
| mask_a | output | 8 | Bytemask for the first byte lane |
| mask_b | output | 8 | Bytemask for the second byte lane |
| xpre_stb | output | 1 | Extended precharge of `x_bank` |
| x_bank | output | 5 | Bank of the last extended precharge |
| cal_stb | output | 1 | Output current calibrate |
| sam_stb | output | 1 | Current sample, issued with calibrate |

## Verification
The bench drives every column opcode, including the three reserved values, with and without the relax bit. A decoder with a wrong opcode table would raise the wrong strobe or a strobe for a reserved value. It sends packets whose device field or extended device field is one off from `dev_id`, and packets with `attn` low; a matcher that ignored either one would issue commands it should drop. Bytemask parts are sent with a write pending, with no write at all, and after a read that ended the pending state. A design that kept the pending state too long would deliver a mask where it should flag an orphan, and one that let an orphan load the masks would corrupt `mask_a`. A back-to-back pair of packets, with data bits high on the start pin inside the packets, exposes any framer that re-arms too early or too late.

// File: rtl/colpkt_pkg.sv
package colpkt_pkg;

   typedef struct packed {
      logic rd;
      logic wr;
      logic pre;
      logic relax;
   } cop_cmd_t;

   typedef struct packed {
      logic pre;
      logic relax;
      logic cal;
      logic sam;
   } xop_cmd_t;

endpackage

// File: rtl/colpkt_framer.sv
module colpkt_framer #(
   parameter int NUM_PINS = 5,
   parameter int SLOTS    = 8,
   localparam int PKT_W   = NUM_PINS * SLOTS,
   localparam int CNT_W   = $clog2(SLOTS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins,
   output logic [PKT_W-1:0]    pkt,
   output logic                done
);

   logic             busy;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         pkt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (pins[NUM_PINS-1]) begin
               pkt  <= {pkt[PKT_W-NUM_PINS-1:0], pins};
               busy <= 1'b1;
               cnt  <= CNT_W'(1);
            end
         end else begin
            pkt <= {pkt[PKT_W-NUM_PINS-1:0], pins};
            if (cnt == CNT_W'(SLOTS-1)) begin
               busy <= 1'b0;
               cnt  <= '0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   // R1: a completed packet is reported for a single cycle
   p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R1: the framer is never busy in the cycle it reports a packet
   p_idle_at_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: rtl/colpkt_cop_dec.sv
module colpkt_cop_dec
   import colpkt_pkg::*;
#(
   parameter int OP_W = 4
) (
   input  logic [OP_W-1:0] op,
   output cop_cmd_t        cmd
);

   always_comb begin
      cmd       = '0;
      cmd.relax = op[OP_W-1];
      unique case (op[2:0])
         3'b001: cmd.wr = 1'b1;
         3'b011: cmd.rd = 1'b1;
         3'b100: cmd.pre = 1'b1;
         3'b101: begin cmd.wr = 1'b1; cmd.pre = 1'b1; end
         3'b111: begin cmd.rd = 1'b1; cmd.pre = 1'b1; end
         default: ;
      endcase
   end

endmodule

// File: rtl/colpkt_xop_dec.sv
module colpkt_xop_dec
   import colpkt_pkg::*;
#(
   parameter int XOP_W = 5
) (
   input  logic [XOP_W-1:0] xop,
   output xop_cmd_t         cmd
);

   always_comb begin
      cmd = '0;
      if (!xop[0]) begin
         cmd.pre   = xop[4];
         cmd.cal   = xop[3];
         cmd.sam   = xop[3] & xop[2];
         cmd.relax = xop[1];
      end
   end

endmodule

// File: rtl/colpkt_decoder.sv
module colpkt_decoder
   import colpkt_pkg::*;
#(
   parameter int NUM_PINS       = 5,
   parameter int SLOTS          = 8,
   parameter int CPART_W        = 23,
   parameter int DEV_W          = 5,
   parameter int BANK_W         = 5,
   parameter int COL_W          = 6,
   parameter int OP_W           = 4,
   parameter int MASK_W         = 8,
   parameter int XOP_W          = 5,
   parameter bit XOP_NEEDS_ATTN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_PINS-1:0] col_in,
   input  logic [DEV_W-1:0]  dev_id,
   input  logic              attn,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic              pre_stb,
   output logic              relax_stb,
   output logic [BANK_W-1:0] col_bank,
   output logic [COL_W-1:0]  col_addr,
   output logic              mask_stb,
   output logic              mask_orphan,
   output logic [MASK_W-1:0] mask_a,
   output logic [MASK_W-1:0] mask_b,
   output logic              xpre_stb,
   output logic [BANK_W-1:0] x_bank,
   output logic              cal_stb,
   output logic              sam_stb
);

   localparam int PKT_W    = NUM_PINS * SLOTS;
   localparam int SPART_W  = PKT_W - CPART_W;
   localparam int S_B      = PKT_W - 1;
   localparam int DEV_LO   = S_B - DEV_W;
   localparam int BANK_LO  = DEV_LO - BANK_W;
   localparam int COL_LO   = BANK_LO - COL_W;
   localparam int OP_LO    = COL_LO - OP_W;
   localparam int M_B      = SPART_W - 1;
   localparam int MA_LO    = M_B - MASK_W;
   localparam int MB_LO    = MA_LO - MASK_W;
   localparam int XDEV_LO  = M_B - DEV_W;
   localparam int XBANK_LO = XDEV_LO - BANK_W;
   localparam int XOP_LO   = XBANK_LO - XOP_W;

   if (OP_LO < SPART_W) begin : g_bad_cpart
      $error("column fields do not fit the column part");
   end
   if (MB_LO != 0) begin : g_bad_mask
      $error("two bytemasks and the mode bit must fill the secondary part");
   end
   if (XOP_LO < 0) begin : g_bad_xpart
      $error("extended fields do not fit the secondary part");
   end
   if (OP_W != 4 || XOP_W != 5) begin : g_bad_op
      $error("opcode widths are fixed by the decode tables");
   end

   logic [PKT_W-1:0] pkt;
   logic             done;

   colpkt_framer #(.NUM_PINS(NUM_PINS), .SLOTS(SLOTS)) u_framer (
      .clk   (clk),
      .rst_n (rst_n),
      .pins  (col_in),
      .pkt   (pkt),
      .done  (done)
   );

   cop_cmd_t cop;
   xop_cmd_t xop;

   colpkt_cop_dec #(.OP_W(OP_W)) u_cop (
      .op  (pkt[OP_LO +: OP_W]),
      .cmd (cop)
   );

   colpkt_xop_dec #(.XOP_W(XOP_W)) u_xop (
      .xop (pkt[XOP_LO +: XOP_W]),
      .cmd (xop)
   );

   logic m_bit, col_ok, x_ok, x_attn, pend;

   if (XOP_NEEDS_ATTN) begin : g_xattn
      assign x_attn = attn;
   end else begin : g_xfree
      assign x_attn = 1'b1;
   end

   assign m_bit  = pkt[M_B];
   assign col_ok = done & attn & (pkt[DEV_LO +: DEV_W] == dev_id);
   assign x_ok   = done & !m_bit & x_attn & (pkt[XDEV_LO +: DEV_W] == dev_id);

   wire unused_rsvd = ^{pkt[OP_LO-1:SPART_W], pkt[XOP_LO-1:0], pkt[S_B]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_stb      <= 1'b0;
         wr_stb      <= 1'b0;
         pre_stb     <= 1'b0;
         relax_stb   <= 1'b0;
         col_bank    <= '0;
         col_addr    <= '0;
         mask_stb    <= 1'b0;
         mask_orphan <= 1'b0;
         mask_a      <= '0;
         mask_b      <= '0;
         xpre_stb    <= 1'b0;
         x_bank      <= '0;
         cal_stb     <= 1'b0;
         sam_stb     <= 1'b0;
         pend        <= 1'b0;
      end else begin
         rd_stb      <= col_ok & cop.rd;
         wr_stb      <= col_ok & cop.wr;
         pre_stb     <= col_ok & cop.pre;
         relax_stb   <= (col_ok & cop.relax) | (x_ok & xop.relax);
         xpre_stb    <= x_ok & xop.pre;
         cal_stb     <= x_ok & xop.cal;
         sam_stb     <= x_ok & xop.sam;
         mask_stb    <= done & m_bit & pend;
         mask_orphan <= done & m_bit & !pend;
         if (col_ok && (cop.rd || cop.wr || cop.pre)) begin
            col_bank <= pkt[BANK_LO +: BANK_W];
            col_addr <= pkt[COL_LO +: COL_W];
         end
         if (x_ok && xop.pre) begin
            x_bank <= pkt[XBANK_LO +: BANK_W];
         end
         if (done && m_bit && pend) begin
            mask_a <= pkt[MA_LO +: MASK_W];
            mask_b <= pkt[MB_LO +: MASK_W];
         end
         if (done) begin
            pend <= col_ok & cop.wr;
         end
      end
   end

   // R2: column commands only issue when the device was in attention
   p_attn_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb || wr_stb || pre_stb) |-> $past(attn));

   // R3: a single opcode never yields both a read and a write
   p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && wr_stb));

   // R6: a sample is always paired with a calibrate
   p_sam_with_cal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sam_stb |-> cal_stb);

   // R7/R8: a bytemask is either delivered or flagged, never both
   p_mask_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mask_stb && mask_orphan));

   // R8: an orphan bytemask leaves the held masks alone
   p_orphan_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mask_orphan |-> ($stable(mask_a) && $stable(mask_b)));

   // R9: strobes last one cycle
   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb || wr_stb || xpre_stb || mask_stb) |=> !(rd_stb || wr_stb || xpre_stb || mask_stb));

endmodule

// File: tb/colpkt_decoder_bench.sv
`timescale 1ns/1ps
module colpkt_decoder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] col_in = '0;
   logic [4:0] dev_id = 5'h0B;
   logic       attn = 1'b0;
   logic       rd_stb, wr_stb, pre_stb, relax_stb, mask_stb, mask_orphan;
   logic       xpre_stb, cal_stb, sam_stb;
   logic [4:0] col_bank, x_bank;
   logic [5:0] col_addr;
   logic [7:0] mask_a, mask_b;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   colpkt_decoder u_colpkt_decoder (
      .clk(clk), .rst_n(rst_n), .col_in(col_in), .dev_id(dev_id), .attn(attn),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .pre_stb(pre_stb), .relax_stb(relax_stb),
      .col_bank(col_bank), .col_addr(col_addr), .mask_stb(mask_stb),
      .mask_orphan(mask_orphan), .mask_a(mask_a), .mask_b(mask_b),
      .xpre_stb(xpre_stb), .x_bank(x_bank), .cal_stb(cal_stb), .sam_stb(sam_stb)
   );

   // entry: {attn, packet[39:0], expected {rd,wr,pre,relax,mask,orphan,xpre,cal,sam}}
   localparam int NV = 24;
   localparam logic [49:0] VEC [NV] = '{
      {1'b1, 1'b1,5'h0B,5'd3,6'd9,4'b0011,3'b000,16'h0000, 9'b100000000}, // R3 read
      {1'b1, 1'b1,5'h0B,5'd3,6'd9,4'b0111,3'b000,16'h0000, 9'b101000000}, // R3 read+pre
      {1'b1, 1'b1,5'h0B,5'd3,6'd9,4'b0100,3'b000,16'h0000, 9'b001000000}, // R3 precharge
      {1'b1, 1'b1,5'h0B,5'd3,6'd9,4'b0000,3'b000,16'h0000, 9'b000000000}, // R3 no-op
      {1'b1, 1'b1,5'h0B,5'd3,6'd9,4'b0010,3'b000,16'h0000, 9'b000000000}, // R3 reserved
      {1'b1, 1'b1,5'h0B,5'd3,6'd9,4'b0110,3'b000,16'h0000, 9'b000000000}, // R3 reserved
      {1'b1, 1'b1,5'h0B,5'd3,6'd9,4'b1000,3'b000,16'h0000, 9'b000100000}, // R4 relax
      {1'b1, 1'b1,5'h0B,5'd3,6'd9,4'b1011,3'b000,16'h0000, 9'b100100000}, // R4 read+relax
      {1'b1, 1'b1,5'h0A,5'd3,6'd9,4'b0011,3'b000,16'h0000, 9'b000000000}, // R2 device mismatch
      {1'b1, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b000,5'h0B,5'd7,5'b10000,1'b0, 9'b000000100}, // R5 xpre
      {1'b1, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b000,5'h0B,5'd7,5'b10010,1'b0, 9'b000100100}, // R5 xpre+relax
      {1'b1, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b000,5'h0B,5'd7,5'b01000,1'b0, 9'b000000010}, // R6 cal
      {1'b1, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b000,5'h0B,5'd7,5'b01100,1'b0, 9'b000000011}, // R6 cal+sam
      {1'b1, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b000,5'h0B,5'd7,5'b10001,1'b0, 9'b000000000}, // R6 reserved
      {1'b1, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b000,5'h0C,5'd7,5'b10000,1'b0, 9'b000000000}, // R5 x mismatch
      {1'b1, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b001,16'h1234, 9'b000001000}, // R8 orphan
      {1'b1, 1'b1,5'h0B,5'd4,6'd5,4'b0001,3'b000,16'h0000, 9'b010000000}, // R3 write
      {1'b1, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b001,16'hA53C, 9'b000010000}, // R7 mask
      {1'b1, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b001,16'hFFFF, 9'b000001000}, // R8 orphan
      {1'b1, 1'b1,5'h0B,5'd4,6'd5,4'b0101,3'b000,16'h0000, 9'b011000000}, // R3 write+pre
      {1'b1, 1'b1,5'h0B,5'd3,6'd9,4'b0011,3'b000,16'h0000, 9'b100000000}, // R7 read ends pending
      {1'b1, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b001,16'hFFFF, 9'b000001000}, // R8 orphan
      {1'b0, 1'b1,5'h0B,5'd3,6'd9,4'b0011,3'b000,16'h0000, 9'b000000000}, // R2 no attention
      {1'b0, 1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b000,5'h0B,5'd7,5'b10000,1'b0, 9'b000000000}  // R5 no attention
   };

   function automatic logic [8:0] strobes();
      return {rd_stb, wr_stb, pre_stb, relax_stb, mask_stb, mask_orphan, xpre_stb, cal_stb, sam_stb};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [39:0] p, input logic a);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         attn   = a;
         col_in = p[39-5*k -: 5];
      end
      @(negedge clk);
      col_in = '0;
      @(negedge clk);
   endtask

   initial begin
      #(8ns * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10 reset state
      chk("R10 strobes in reset", 64'(strobes()), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 strobes after reset", 64'(strobes()), 64'd0);
      chk("R10 addresses after reset", {col_bank, col_addr, x_bank, mask_a, mask_b}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         send(VEC[i][48:9], VEC[i][49]);
         chk($sformatf("R1 R9 vector %0d strobes", i), 64'(strobes()), 64'(VEC[i][8:0]));
         @(negedge clk);
         chk($sformatf("R9 vector %0d pulse end", i), 64'(strobes()), 64'd0);
      end

      // R7 R8: delivered mask held, later orphans did not touch it
      chk("R7 mask_a", 64'(mask_a), 64'hA5);
      chk("R8 mask_b held", 64'(mask_b), 64'h3C);

      // R2 bank and column load
      send({1'b1,5'h0B,5'd21,6'd45,4'b0011,3'b000,16'h0000}, 1'b1);
      chk("R2 col_bank", 64'(col_bank), 64'd21);
      chk("R2 col_addr", 64'(col_addr), 64'd45);
      send({1'b1,5'h0B,5'd2,6'd1,4'b0000,3'b000,16'h0000}, 1'b1);
      chk("R2 no-op keeps col_bank", 64'(col_bank), 64'd21);

      // R5 extended bank
      send({1'b1,5'h0B,5'd0,6'd0,4'b0000,3'b000,5'h0B,5'd19,5'b10000,1'b0}, 1'b1);
      chk("R5 x_bank", 64'(x_bank), 64'd19);

      // R1 back-to-back packets
      begin
         logic [79:0] pp;
         pp = {1'b1,5'h0B,5'd2,6'd3,4'b0011,3'b000,16'h0000,
               1'b1,5'h0B,5'd6,6'd7,4'b0001,3'b000,16'h0000};
         for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (k == 9) chk("R1 first of pair read", 64'(strobes()), 64'b100000000);
            attn   = 1'b1;
            col_in = pp[79-5*k -: 5];
         end
         @(negedge clk);
         col_in = '0;
         @(negedge clk);
         chk("R1 second of pair write", 64'(strobes()), 64'b010000000);
         chk("R1 second of pair bank", 64'(col_bank), 64'd6);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule